// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

A single pulse-width-modulation channel. A 24-bit up-counter runs in its own counter clock domain. A prescaler lets the counter advance once every 1, 16, 256 or 2048 counter clocks. The counter counts from zero to one less than the programmed period and then wraps. The output is active while the count is below the programmed duty. A polarity bit swaps the high and low phases. Duty values from zero up to the period, and beyond it, give the full 0% to 100% range.

Software reaches the channel through a small word-wide register bus clocked by its own, fully asynchronous clock. Each accepted write is passed to the counter domain through a toggle request and acknowledge handshake. While a transfer is in flight, the channel reports busy and ignores further writes. New period and duty values wait in shadow registers. They go live at the next counter wrap, or at once while the channel is stopped.

Three sticky event flags record a rising output edge, a falling output edge and a counter wrap. The interrupt line, driven in the counter domain, is the OR of the flags whose enables are set.

Top module: `pwm_prescaled_channel`

## Requirements
- R1: After reset, pwm_out and irq are 0 and every register reads 0.
- R2: While running, the counter steps from 0 to P-1 and wraps, where P is the period register. A period of 0 or 1 gives a one-step period.
- R3: CTRL[3:2] selects how many counter clocks make one counter step: 0 gives 1, 1 gives 16, 2 gives 256 and 3 gives 2048.
- R4: In each period the output is active for min(D, P) steps, where D is the duty register. D = 0 is never active, and D >= P is always active. With prescale code 0, one step is one counter clock.
- R5: CTRL[1] = 0 makes the active level high. CTRL[1] = 1 inverts the output.
- R6: With CTRL[0] (run) at 0, the counter holds at zero and pwm_out sits at the inactive level, which equals CTRL[1].
- R7: STATUS (address 3) bit 0 records a rising output edge, bit 1 a falling output edge and bit 2 a counter wrap. The bits are set whatever the enables, stay set until a 1 is written to them, and irq = OR of (STATUS[2:0] & CTRL[6:4]).
- R8: STATUS bit 8 (busy) is set from an accepted write until the counter domain acknowledges it. A write issued while busy is ignored.
- R9: A period or duty write made while running takes effect at the next counter wrap. While stopped, it takes effect at once.
- R10: Operation is correct whether the counter clock is faster or slower than the bus clock.

Register addresses: 0 = CTRL (bit 0 run, bit 1 polarity, bits 3:2 prescale, bits 6:4 enables for rise, fall and wrap), 1 = PERIOD, 2 = DUTY, 3 = STATUS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Register bus clock |
| brst_n | input | 1 | Bus domain reset, active low |
| bus_wen | input | 1 | Write strobe, one bus clock per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for bus_addr (combinational) |
| cclk | input | 1 | Counter clock |
| crst_n | input | 1 | Counter domain reset, active low |
| pwm_out | output | 1 | PWM output (counter domain) |
| irq | output | 1 | Combined interrupt (counter domain) |

## Verification
The bench builds the channel with its default 24-bit counter and the full 11-bit prescaler. Because of this, the 2048 ratio is measured directly with a short period. The counter clock runs first faster and then slower than the 100 MHz bus clock, so the handshake and the status synchronisers are exercised in both ratios. Random periods below 21, duties up to 25 and a choice of polarity place duty-over-period, zero duty and zero period cases within a few hundred counter clocks.

// File: rtl/pwm_prescaled_channel.sv
module pwm_prescaled_channel #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 11
) (
  input  logic             bclk,
  input  logic             brst_n,
  input  logic             bus_wen,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             cclk,
  input  logic             crst_n,
  output logic             pwm_out,
  output logic             irq
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  // bus domain
  logic [6:0]       ctrl_b;
  logic [CNT_W-1:0] per_b, duty_b;
  logic [2:0]       clr_b;
  logic             req_t;
  logic [1:0]       ack_sy;
  logic [2:0]       st_s1, st_s2;
  logic             busy;
  logic             ack_t;
  logic [2:0]       st_c;

  assign busy = req_t ^ ack_sy[1];

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      ctrl_b <= '0; per_b <= '0; duty_b <= '0; clr_b <= '0;
      req_t <= 1'b0; ack_sy <= '0; st_s1 <= '0; st_s2 <= '0;
    end else begin
      ack_sy <= {ack_sy[0], ack_t};
      st_s1  <= st_c;
      st_s2  <= st_s1;
      if (bus_wen && !busy) begin
        req_t <= ~req_t;
        clr_b <= '0;
        case (bus_addr)
          2'd0: ctrl_b <= bus_wdata[6:0];
          2'd1: per_b  <= bus_wdata;
          2'd2: duty_b <= bus_wdata;
          default: clr_b <= bus_wdata[2:0];
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata[6:0] = ctrl_b;
      2'd1: bus_rdata = per_b;
      2'd2: bus_rdata = duty_b;
      default: begin
        bus_rdata[2:0] = st_s2;
        bus_rdata[8]   = busy;
      end
    endcase
  end

  a_r8_busy_blocks: assert property (@(posedge bclk) disable iff (!brst_n)
    (busy && bus_wen) |=> ($stable(ctrl_b) && $stable(per_b) && $stable(duty_b)));

  // counter domain
  logic [1:0]       req_sy;
  logic             capture;
  logic             run_c, pol_c;
  logic [1:0]       presc_c;
  logic [2:0]       ien_c;
  logic [CNT_W-1:0] per_s, duty_s, per_a, duty_a, cnt;
  logic [PRE_W-1:0] pre, lim;
  logic             tick, wrap, act, pin_n, pin_q;
  logic [2:0]       ev;

  assign capture = req_sy[1] ^ ack_t;

  always_comb begin
    case (presc_c)
      2'd0:    lim = PRE_W'(0);
      2'd1:    lim = PRE_W'(15);
      2'd2:    lim = PRE_W'(255);
      default: lim = PRE_W'(2047);
    endcase
  end

  assign tick  = run_c && (pre == lim);
  assign wrap  = ({1'b0, cnt} + ONE) >= {1'b0, per_a};
  assign act   = run_c && (cnt < duty_a);
  assign pin_n = act ^ pol_c;
  assign ev    = {tick && wrap, pin_q & ~pin_n, ~pin_q & pin_n};
  assign pwm_out = pin_q;
  assign irq     = |(st_c & ien_c);

  always_ff @(posedge cclk or negedge crst_n) begin
    if (!crst_n) begin
      req_sy <= '0; ack_t <= 1'b0;
      run_c <= 1'b0; pol_c <= 1'b0; presc_c <= '0; ien_c <= '0;
      per_s <= '0; duty_s <= '0; per_a <= '0; duty_a <= '0;
      cnt <= '0; pre <= '0; pin_q <= 1'b0; st_c <= '0;
    end else begin
      req_sy <= {req_sy[0], req_t};
      ack_t  <= req_sy[1];
      if (capture) begin
        run_c   <= ctrl_b[0];
        pol_c   <= ctrl_b[1];
        presc_c <= ctrl_b[3:2];
        ien_c   <= ctrl_b[6:4];
        per_s   <= per_b;
        duty_s  <= duty_b;
      end
      st_c  <= (st_c & ~(capture ? clr_b : 3'b000)) | ev;
      pin_q <= pin_n;
      if (!run_c) begin
        pre <= '0; cnt <= '0; per_a <= per_s; duty_a <= duty_s;
      end else if (tick) begin
        pre <= '0;
        if (wrap) begin
          cnt <= '0; per_a <= per_s; duty_a <= duty_s;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  a_r2_count_in_range: assert property (@(posedge cclk) disable iff (!crst_n)
    (cnt == '0) || (cnt < per_a));
  a_r6_stop_inactive: assert property (@(posedge cclk) disable iff (!crst_n)
    !run_c |=> (pwm_out == $past(pol_c)));
  a_r4_zero_duty: assert property (@(posedge cclk) disable iff (!crst_n)
    (run_c && duty_a == '0) |=> (pwm_out == $past(pol_c)));
  a_r9_shadow_load: assert property (@(posedge cclk) disable iff (!crst_n)
    $changed(per_a) |-> $past(!run_c || (tick && wrap)));
  a_r7_sticky: assert property (@(posedge cclk) disable iff (!crst_n)
    (st_c[2] && !capture) |=> st_c[2]);
  a_r7_irq_needs_flag: assert property (@(posedge cclk) disable iff (!crst_n)
    irq |-> (st_c != 3'b000));
endmodule

// File: tb/tb_pwm_prescaled_channel.sv
`timescale 1ns/1ps
module tb_pwm_prescaled_channel;
  logic bclk = 0, cclk = 0, brst_n = 0, crst_n = 0;
  logic bus_wen = 0;
  logic [1:0] bus_addr = 0;
  logic [23:0] bus_wdata = 0, bus_rdata;
  logic pwm_out, irq;
  int chalf = 3;
  int errs = 0, checks = 0;
  bit done = 0;

  pwm_prescaled_channel dut (.bclk(bclk), .brst_n(brst_n), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cclk(cclk), .crst_n(crst_n), .pwm_out(pwm_out), .irq(irq));

  always #5 bclk = ~bclk;
  always #(chalf) cclk = ~cclk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int divof(input int code);
    case (code)
      0: return 1;
      1: return 16;
      2: return 256;
      default: return 2048;
    endcase
  endfunction

  function automatic int exp_hi(input int per, input int duty, input int div, input int pol, input int k);
    int p, h;
    p = (per == 0) ? 1 : per;
    h = ((duty < p) ? duty : p) * div * k;
    return pol ? (p * div * k - h) : h;
  endfunction

  task automatic brd(input logic [1:0] a, output logic [23:0] d);
    @(negedge bclk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [23:0] v;
    do brd(2'd3, v); while (v[8]);
  endtask

  task automatic raw_wr(input logic [1:0] a, input logic [23:0] d);
    @(negedge bclk); bus_wen = 1; bus_addr = a; bus_wdata = d;
    @(negedge bclk); bus_wen = 0;
  endtask

  task automatic bwr(input logic [1:0] a, input logic [23:0] d);
    wait_idle(); raw_wr(a, d);
  endtask

  task automatic measure(input int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge cclk); hi += int'(pwm_out); end
  endtask

  function automatic logic [23:0] ctrlw(input int run, input int pol, input int presc, input int ien);
    return 24'(run | (pol << 1) | (presc << 2) | (ien << 4));
  endfunction

  task automatic run_and_check(input int per, input int duty, input int presc, input int pol, input string req);
    int div, p, hi, e;
    div = divof(presc);
    p = (per == 0) ? 1 : per;
    bwr(2'd0, ctrlw(0, pol, presc, 0));
    bwr(2'd1, 24'(per));
    bwr(2'd2, 24'(duty));
    bwr(2'd0, ctrlw(1, pol, presc, 0));
    wait_idle();
    repeat (p * div * 2 + 8) @(negedge cclk);
    measure(p * div * 2, hi);
    e = exp_hi(per, duty, div, pol, 2);
    chk(hi == e, req, hi, e);
  endtask

  initial begin
    #1900000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    int hi, seed;
    seed = int'($urandom(32'd2024));
    repeat (4) @(negedge bclk);
    brst_n = 1; crst_n = 1;
    repeat (2) @(negedge bclk);
    // R1 reset
    chk(pwm_out == 0, "R1 pwm_out", int'(pwm_out), 0);
    chk(irq == 0, "R1 irq", int'(irq), 0);
    brd(2'd3, v); chk(v == 0, "R1 status", int'(v), 0);
    brd(2'd1, v); chk(v == 0, "R1 period", int'(v), 0);

    // R8 busy and ignored write
    raw_wr(2'd1, 24'd5);
    brd(2'd3, v); chk(v[8] == 1'b1, "R8 busy set", int'(v[8]), 1);
    raw_wr(2'd1, 24'd9);
    wait_idle();
    brd(2'd1, v); chk(v == 24'd5, "R8 write ignored while busy", int'(v), 5);

    // fast counter clock: R2 R3 R4 R5 R10
    for (int i = 0; i < 8; i++) begin
      int per, duty, presc, pol;
      per = int'($urandom_range(20, 1)); duty = int'($urandom_range(25, 0));
      presc = int'($urandom_range(2, 0)); pol = int'($urandom_range(1, 0));
      if (presc == 2) per = (per > 4) ? 4 : per;
      run_and_check(per, duty, presc, pol, "R4 R5 R10 random fast");
    end
    run_and_check(6, 0, 0, 0, "R4 duty zero");
    run_and_check(6, 6, 0, 0, "R4 duty equals period");
    run_and_check(6, 40, 0, 1, "R4 R5 duty above period inverted");
    run_and_check(0, 1, 0, 0, "R2 period zero");
    run_and_check(2, 1, 3, 0, "R3 divide by 2048");
    run_and_check(3, 1, 1, 1, "R3 divide by 16");

    // R9 change duty while running
    run_and_check(10, 3, 0, 0, "R9 before change");
    bwr(2'd2, 24'd7);
    wait_idle();
    repeat (30) @(negedge cclk);
    measure(20, hi); chk(hi == 14, "R9 duty change at wrap", hi, 14);

    // R6 stop with inverted polarity
    bwr(2'd0, ctrlw(0, 1, 0, 0));
    wait_idle(); repeat (6) @(negedge cclk);
    measure(50, hi); chk(hi == 50, "R6 stopped at inactive level", hi, 50);
    bwr(2'd0, ctrlw(0, 0, 0, 0));
    wait_idle(); repeat (6) @(negedge cclk);
    measure(50, hi); chk(hi == 0, "R6 stopped low", hi, 0);

    // R7 interrupts
    bwr(2'd1, 24'd4); bwr(2'd2, 24'd2);
    bwr(2'd0, ctrlw(1, 0, 0, 1));
    wait_idle(); repeat (20) @(negedge cclk); repeat (4) @(negedge bclk);
    brd(2'd3, v); chk(v[2:0] == 3'b111, "R7 all flags set", int'(v[2:0]), 7);
    @(negedge cclk); chk(irq == 1, "R7 irq enabled rise", int'(irq), 1);
    bwr(2'd0, ctrlw(0, 0, 0, 1));
    wait_idle(); repeat (20) @(negedge cclk);
    bwr(2'd3, 24'd7);
    wait_idle(); repeat (6) @(negedge cclk); repeat (4) @(negedge bclk);
    brd(2'd3, v); chk(v[2:0] == 3'b000, "R7 write one clears", int'(v[2:0]), 0);
    @(negedge cclk); chk(irq == 0, "R7 irq cleared", int'(irq), 0);
    bwr(2'd2, 24'd0);
    bwr(2'd0, ctrlw(1, 0, 0, 0));
    wait_idle(); repeat (20) @(negedge cclk); repeat (4) @(negedge bclk);
    brd(2'd3, v); chk(v[2:0] == 3'b100, "R7 only wrap at duty zero", int'(v[2:0]), 4);
    @(negedge cclk); chk(irq == 0, "R7 irq masked", int'(irq), 0);
    bwr(2'd0, ctrlw(1, 0, 0, 4));
    wait_idle(); repeat (4) @(negedge cclk);
    chk(irq == 1, "R7 irq wrap enabled", int'(irq), 1);

    // slow counter clock: R10
    chalf = 17;
    repeat (10) @(negedge cclk);
    for (int i = 0; i < 4; i++) begin
      int per, duty, pol;
      per = int'($urandom_range(12, 1)); duty = int'($urandom_range(14, 0));
      pol = int'($urandom_range(1, 0));
      run_and_check(per, duty, int'($urandom_range(1, 0)), pol, "R10 R4 random slow");
    end
    run_and_check(5, 2, 0, 1, "R10 R5 slow inverted");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule